// File: doc/BRIEF.md
# DRAM address-map configuration selector

This block picks the address-mapping configuration number that a memory scheduler should use for a DRAM device whose geometry has already been measured. It is given the measured column-address count and row-address count, a flag that marks a 16-bit data bus, and the mapping scheme that the system wants. It then walks a fixed sixteen-entry table of (rows, columns, scheme) triples from entry 0 upwards, testing one entry per clock. It returns the first entry that satisfies the rule for the requested scheme. If no entry does, it raises a not-found flag.

The table is laid out for a 32-bit bus, so on a 16-bit bus one column bit is consumed and the effective column count is one less than the measured count. A controller pulses `start` and waits for the one-cycle `done` pulse. The result stays on `cfg_index` and `not_found` until the next search writes a new one.

The controller has three states. IDLE waits for a request. SCAN tests one table entry per cycle. FIN presents `done` for one cycle. The transitions are:
- IDLE to SCAN: on `start`.
- SCAN to FIN: on a hit, or on a miss at entry 15.
- SCAN to SCAN: on a miss at any other entry.
- FIN to IDLE: unconditionally.

Top module: `addrmap_cfg_select`

## Requirements
- R1: When `half_bus` is 1 at `start`, the entry column values are compared against `col_cnt - 1`. When it is 0, they are compared against `col_cnt` unchanged.
- R2: For scheme code 0 (column-bank-row-device), only table entries 0..10 are candidates, and an entry hits only when its columns and its rows both equal the request. Those entries hold (rows, cols) = 0:(13,10), 1:(14,10), 2:(15,10), 3:(16,10), 4:(14,11), 5:(15,11), 6:(16,11), 7:(13,9), 8:(14,9), 9:(15,9), 10:(16,9).
- R3: For scheme code 1 (column-row-bank-device), only entries 11:(15,10), 12:(14,11) and 13:(13,10) are candidates. An entry hits when its columns equal the request and its rows are less than or equal to the requested rows.
- R4: For scheme code 2 (column-bank-device-row), only entries 14:(16,10) and 15:(16,9) are candidates. An entry hits when its columns equal the request, or when its columns are at most the requested columns and its rows equal the requested rows.
- R5: Scheme code 3 has no table entries, so every request with code 3 ends with `not_found` = 1.
- R6: When several candidates would hit, the one with the lowest index is reported.
- R7: When no candidate hits, `not_found` is 1 and `cfg_index` is 0. After a hit, `not_found` is 0.
- R8: `done` is high for exactly one cycle. For a hit at entry k, it is seen k+1 clock edges after the edge that samples `start`. For a miss, it is seen 16 edges after that edge.
- R9: A `start` that arrives during a search is ignored. Changes on `col_cnt`, `row_cnt`, `half_bus` and `scheme` after the sampling edge do not affect the running search.
- R10: After reset, `done`, `cfg_index` and `not_found` are 0. `cfg_index` and `not_found` keep their values from one result until the next result is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a search; sampled only in IDLE |
| col_cnt | input | COL_W (4) | Measured column-address bits |
| row_cnt | input | ROW_W (5) | Measured row-address bits |
| half_bus | input | 1 | 1 = 16-bit data bus, 0 = 32-bit |
| scheme | input | 2 | Requested mapping scheme code (0..3) |
| done | output | 1 | One-cycle completion pulse |
| cfg_index | output | 4 | Selected table entry |
| not_found | output | 1 | No entry satisfied the rule |

## Verification
A hit on the last table entry and the end-of-table miss are decided in the same SCAN cycle, when the cursor sits on entry 15. The bench provokes this by requesting scheme 2 with 9 effective columns, once directly and once through the half-bus adjustment. For each case it expects index 15, `not_found` low and the full 16-edge latency, so that a miss verdict cannot overwrite a hit. A second overlap is a new `start` arriving while a scan is in progress. The bench judges that case by checking that the first request's index and latency are unchanged.

// File: rtl/amsel_pkg.sv
package amsel_pkg;

    localparam int ENTRIES = 16;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int TROW_W  = 5;
    localparam int TCOL_W  = 4;

    typedef enum logic [1:0] {
        SCH_CBRD = 2'd0,
        SCH_CRBD = 2'd1,
        SCH_CBDR = 2'd2,
        SCH_RSVD = 2'd3
    } scheme_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_FIN  = 2'd2
    } state_e;

    typedef struct packed {
        logic [TROW_W-1:0] rows;
        logic [TCOL_W-1:0] cols;
        scheme_e           kind;
    } entry_t;

    function automatic entry_t mk(input int r, input int c, input scheme_e k);
        entry_t e;
        e.rows = TROW_W'(r);
        e.cols = TCOL_W'(c);
        e.kind = k;
        return e;
    endfunction

    function automatic entry_t entry_at(input logic [IDX_W-1:0] i);
        entry_t e;
        case (i)
            4'd0:    e = mk(13, 10, SCH_CBRD);
            4'd1:    e = mk(14, 10, SCH_CBRD);
            4'd2:    e = mk(15, 10, SCH_CBRD);
            4'd3:    e = mk(16, 10, SCH_CBRD);
            4'd4:    e = mk(14, 11, SCH_CBRD);
            4'd5:    e = mk(15, 11, SCH_CBRD);
            4'd6:    e = mk(16, 11, SCH_CBRD);
            4'd7:    e = mk(13,  9, SCH_CBRD);
            4'd8:    e = mk(14,  9, SCH_CBRD);
            4'd9:    e = mk(15,  9, SCH_CBRD);
            4'd10:   e = mk(16,  9, SCH_CBRD);
            4'd11:   e = mk(15, 10, SCH_CRBD);
            4'd12:   e = mk(14, 11, SCH_CRBD);
            4'd13:   e = mk(13, 10, SCH_CRBD);
            4'd14:   e = mk(16, 10, SCH_CBDR);
            default: e = mk(16,  9, SCH_CBDR);
        endcase
        return e;
    endfunction

endpackage

// File: rtl/amsel_table.sv
module amsel_table
    import amsel_pkg::*;
#(
    parameter int COL_W = 4,
    parameter int ROW_W = 5
) (
    input  logic [IDX_W-1:0] idx,
    output logic [COL_W-1:0] ent_cols,
    output logic [ROW_W-1:0] ent_rows,
    output scheme_e          ent_kind
);

    entry_t e;

    always_comb begin
        e        = entry_at(idx);
        ent_cols = COL_W'(e.cols);
        ent_rows = ROW_W'(e.rows);
        ent_kind = e.kind;
    end

endmodule

// File: rtl/amsel_match.sv
module amsel_match
    import amsel_pkg::*;
#(
    parameter int COL_W = 4,
    parameter int ROW_W = 5
) (
    input  scheme_e          req_kind,
    input  logic [COL_W-1:0] req_cols,
    input  logic [ROW_W-1:0] req_rows,
    input  scheme_e          ent_kind,
    input  logic [COL_W-1:0] ent_cols,
    input  logic [ROW_W-1:0] ent_rows,
    output logic             hit
);

    logic cols_eq;
    logic cols_le;
    logic rows_eq;
    logic rows_le;

    always_comb begin
        cols_eq = (ent_cols == req_cols);
        cols_le = (ent_cols <= req_cols);
        rows_eq = (ent_rows == req_rows);
        rows_le = (ent_rows <= req_rows);
        hit     = 1'b0;
        if (ent_kind == req_kind) begin
            unique case (req_kind)
                SCH_CBRD: hit = cols_eq && rows_eq;              // R2
                SCH_CRBD: hit = cols_eq && rows_le;              // R3
                SCH_CBDR: hit = cols_eq || (cols_le && rows_eq); // R4
                default:  hit = 1'b0;                            // R5
            endcase
        end
    end

endmodule

// File: rtl/addrmap_cfg_select.sv
module addrmap_cfg_select
    import amsel_pkg::*;
#(
    parameter int COL_W = 4,
    parameter int ROW_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] col_cnt,
    input  logic [ROW_W-1:0] row_cnt,
    input  logic             half_bus,
    input  logic [1:0]       scheme,
    output logic             done,
    output logic [IDX_W-1:0] cfg_index,
    output logic             not_found
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    state_e           state_q, state_d;
    logic [IDX_W-1:0] cursor_q;
    logic [COL_W-1:0] cols_q;
    logic [ROW_W-1:0] rows_q;
    scheme_e          scheme_q;
    logic [IDX_W-1:0] index_q;
    logic             miss_q;

    logic [COL_W-1:0] ent_cols;
    logic [ROW_W-1:0] ent_rows;
    scheme_e          ent_kind;
    logic             hit;

    amsel_table #(.COL_W(COL_W), .ROW_W(ROW_W)) u_table (
        .idx      (cursor_q),
        .ent_cols (ent_cols),
        .ent_rows (ent_rows),
        .ent_kind (ent_kind)
    );

    amsel_match #(.COL_W(COL_W), .ROW_W(ROW_W)) u_match (
        .req_kind (scheme_q),
        .req_cols (cols_q),
        .req_rows (rows_q),
        .ent_kind (ent_kind),
        .ent_cols (ent_cols),
        .ent_rows (ent_rows),
        .hit      (hit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_SCAN;
            ST_SCAN: if (hit || cursor_q == LAST) state_d = ST_FIN;
            ST_FIN:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Request latch, cursor and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cursor_q <= '0;
            cols_q   <= '0;
            rows_q   <= '0;
            scheme_q <= SCH_CBRD;
            index_q  <= '0;
            miss_q   <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                cursor_q <= '0;
                cols_q   <= half_bus ? (col_cnt - COL_W'(1)) : col_cnt; // R1
                rows_q   <= row_cnt;
                scheme_q <= scheme_e'(scheme);
            end else if (state_q == ST_SCAN) begin
                if (hit) begin
                    index_q <= cursor_q;
                    miss_q  <= 1'b0;
                end else if (cursor_q == LAST) begin
                    index_q <= '0;
                    miss_q  <= 1'b1;
                end else begin
                    cursor_q <= cursor_q + IDX_W'(1);
                end
            end
        end
    end

    // Outputs
    always_comb begin
        done      = (state_q == ST_FIN);
        cfg_index = index_q;
        not_found = miss_q;
    end

    // R8: completion is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: a hit from the comparator ends the scan on the next edge
    a_r6_hit_ends_scan: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && hit) |=> (done && !not_found && cfg_index == $past(cursor_q)));

    // R7: a miss reports index zero
    a_r7_miss_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && not_found) |-> (cfg_index == '0));

    // R5: the reserved scheme never produces a hit
    a_r5_reserved_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (done && scheme_q == SCH_RSVD) |-> not_found);

    // R10: results only change when a scan writes them
    a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_SCAN) |=> ($stable(cfg_index) && $stable(not_found)));

    // R9: a start during a scan does not restart it
    a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && start && !hit && cursor_q != LAST) |=> (cursor_q == $past(cursor_q) + IDX_W'(1)));

endmodule

// File: tb/tb_addrmap_cfg_select.sv
module tb_addrmap_cfg_select;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] col_cnt = '0;
    logic [4:0] row_cnt = '0;
    logic       half_bus = 1'b0;
    logic [1:0] scheme = '0;
    logic       done;
    logic [3:0] cfg_index;
    logic       not_found;

    int checks = 0;
    int failures = 0;
    int wd = 0;

    addrmap_cfg_select dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .col_cnt   (col_cnt),
        .row_cnt   (row_cnt),
        .half_bus  (half_bus),
        .scheme    (scheme),
        .done      (done),
        .cfg_index (cfg_index),
        .not_found (not_found)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 100000) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired act=%0d exp=<100000", wd);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    localparam int NV = 17;
    // scheme, cols, rows, half_bus, expected index, expected miss
    localparam int V_SCH [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 2, 2, 2, 2, 2, 3};
    localparam int V_COL [NV] = '{10,11, 9,11,11,12,10,10,11,11, 9,10, 9,11,11,10,10};
    localparam int V_ROW [NV] = '{13,16,16,13,14,15,16,13,14,13,16,13,12,16,15,16,13};
    localparam int V_HLF [NV] = '{0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0};
    localparam int V_IDX [NV] = '{0, 6,10, 0, 1, 5,11,13,12, 0, 0,14,15,14, 0,15, 0};
    localparam int V_ERR [NV] = '{0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 1, 0, 1};

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s act=%0d exp=%0d", what, act, exp);
        end
    endtask

    function automatic string tag_of(input int s);
        case (s)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic run(input int s, input int c, input int r, input int h,
                       output int idx, output int er, output int lat, output int pulse_ok);
        @(negedge clk);
        scheme = 2'(s); col_cnt = 4'(c); row_cnt = 5'(r); half_bus = h[0]; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 40) begin
            @(posedge clk); lat++; @(negedge clk);
        end
        idx = cfg_index; er = not_found;
        @(posedge clk); @(negedge clk);
        pulse_ok = !done;
    endtask

    initial begin
        int idx, er, lat, pk;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset values
        chk(done == 1'b0, "R10 reset done", done, 0);
        chk(cfg_index == 4'd0, "R10 reset index", cfg_index, 0);
        chk(not_found == 1'b0, "R10 reset not_found", not_found, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            string t;
            int exp_lat;
            t = tag_of(V_SCH[v]);
            if (V_HLF[v] != 0) t = {t, "/R1"};
            exp_lat = (V_ERR[v] != 0) ? 16 : V_IDX[v] + 1;
            run(V_SCH[v], V_COL[v], V_ROW[v], V_HLF[v], idx, er, lat, pk);
            chk(idx == V_IDX[v], $sformatf("%s/R6 vec%0d index", t, v), idx, V_IDX[v]);
            chk(er == V_ERR[v], $sformatf("%s/R7 vec%0d not_found", t, v), er, V_ERR[v]);
            chk(lat == exp_lat, $sformatf("R8 vec%0d latency", v), lat, exp_lat);
            chk(pk == 1, $sformatf("R8 vec%0d single pulse", v), pk, 1);
        end

        // R10: results hold while idle, with inputs moving
        run(0, 11, 16, 0, idx, er, lat, pk);
        scheme = 2'd3; col_cnt = 4'd9; row_cnt = 5'd12; half_bus = 1'b1;
        repeat (5) begin @(posedge clk); @(negedge clk); end
        chk(cfg_index == 4'd6, "R10 index held while idle", cfg_index, 6);
        chk(not_found == 1'b0, "R10 not_found held while idle", not_found, 0);
        chk(done == 1'b0, "R10 no done while idle", done, 0);

        // R9: restart and input changes during a scan are ignored
        @(negedge clk);
        scheme = 2'd0; col_cnt = 4'd9; row_cnt = 5'd16; half_bus = 1'b0; start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 40) begin
            if (lat == 3) begin
                start = 1'b1; scheme = 2'd2; col_cnt = 4'd10; row_cnt = 5'd13; half_bus = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(posedge clk); lat++; @(negedge clk);
        end
        start = 1'b0;
        chk(cfg_index == 4'd10, "R9 index after busy start", cfg_index, 10);
        chk(not_found == 1'b0, "R9 not_found after busy start", not_found, 0);
        chk(lat == 11, "R9 latency after busy start", lat, 11);
        @(posedge clk); @(negedge clk);
        chk(done == 1'b0, "R9 no second done", done, 0);
        repeat (20) begin @(posedge clk); @(negedge clk); end
        chk(done == 1'b0, "R9 no restarted search", done, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule